// File: doc/BRIEF.md
# Keyboard-Style Serial Link Transmitter (Device Side)

This block is the device end of a two-wire PS/2 link. The device generates the bus clock itself and shifts one byte to the host on the data line. Both wires are open-drain with pull-ups. The block therefore has one drive-low enable per wire and reads the resolved level of each wire back through a synchronizer. A client hands over a byte with a valid/ready handshake. When the frame ends, the block answers with a one-cycle completion pulse or a one-cycle abort pulse.

Before each frame, the block waits until both wires have read high without a break for an idle window. It then sends eleven bits: a low start bit, the byte least significant bit first, an odd parity bit and a released stop bit. Counters set the length of every clock phase and the point at which data changes. The counter limits come from the system clock frequency, so the timing stays the same in microseconds for any system clock. The host can inhibit the bus by holding the clock low. The block looks for this only while it is itself releasing the clock. If it sees the clock low then, it releases both wires and reports an abort, and the client decides whether to send the byte again.

Top module: `ps2_dev_tx`

## Requirements
- R1: While reset is high and in the first cycle after it, both drive-low enables are 0, tx_ready is 1, and tx_done and tx_abort are 0.
- R2: The values on the data wire at the eleven falling edges of the bus clock are, in order: 0, byte bits 0 to 7, a parity bit that makes the count of ones over byte and parity odd, then 1.
- R3: Every low phase of the bus clock, and every high phase after the first falling edge, lasts HALF_US microseconds (default 40) of system clock cycles.
- R4: The data wire changes only while the bus clock is high. Within a frame, a change comes exactly LEAD_US microseconds (default 20) before the next falling edge.
- R5: After a byte is accepted, nothing is driven until both wires have read high without a break for IDLE_US microseconds (default 50). While the host holds the clock low, both enables stay 0.
- R6: If the clock wire reads low while the block is releasing it, both enables drop to 0 in the cycle that tx_abort pulses. No completion pulse follows, and no further falling edges come from the block.
- R7: After the eleventh low phase ends, tx_done pulses for exactly one cycle, both enables are 0 in that cycle, and tx_ready returns to 1.
- R8: tx_ready is 0 from acceptance until tx_done or tx_abort. A byte offered while tx_ready is 0 is ignored and is never sent.
- R9: The inhibit check covers the high phase that follows the tenth falling edge, so a hold there aborts. A hold that starts after tx_done produces no abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_byte | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Idle and able to accept a byte |
| ps2_clk_in | input | 1 | Resolved level of the bus clock wire |
| ps2_data_in | input | 1 | Resolved level of the bus data wire |
| ps2_clk_drive_low | output | 1 | 1 pulls the clock wire low, 0 releases it |
| ps2_data_drive_low | output | 1 | 1 pulls the data wire low, 0 releases it |
| tx_done | output | 1 | One-cycle pulse: frame completed |
| tx_abort | output | 1 | One-cycle pulse: frame inhibited by the host |

## Verification
The hardest case to reach from the ports is an inhibit during the last checked high phase. The host must pull the clock low after the tenth falling edge, late enough that the block has released the clock and its synchronizer has seen the wire high, but before the eleventh fall. The bench models the host on the resolved wires, counts the falling edges it sees, and starts a 150-cycle hold ten cycles into the chosen high phase. It uses the same mechanism after the third fall, and again right after completion to confirm that no abort follows.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

  localparam int FRAME_BITS = 11;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_HIGH = 2'd2,
    S_LOW  = 2'd3
  } tx_state_t;

  // start(0) | byte LSB first | odd parity | stop(1), bit 0 goes out first
  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [7:0] b);
    return {1'b1, ~^b, b, 1'b0};
  endfunction

endpackage

// File: rtl/ps2tx_sync.sv
module ps2tx_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  // idle bus reads high, so the chain resets to 1
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], d_in[i]};
    end
    assign d_out[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/ps2tx_timer.sv
module ps2tx_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else            count <= count + 1'b1;
  end
endmodule

// File: rtl/ps2tx_frame.sv
module ps2tx_frame
  import ps2tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       shift,
  input  logic [7:0] byte_in,
  output logic       bit_out
);
  logic [FRAME_BITS-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst)        shreg <= '1;
    else if (load)  shreg <= build_frame(byte_in);
    else if (shift) shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
  end

  assign bit_out = shreg[0];
endmodule

// File: rtl/ps2_dev_tx.sv
module ps2_dev_tx
  import ps2tx_pkg::*;
#(
  parameter int CLK_HZ      = 125_000_000,
  parameter int HALF_US     = 40,
  parameter int LEAD_US     = 20,
  parameter int IDLE_US     = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] tx_byte,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic       ps2_clk_in,
  input  logic       ps2_data_in,
  output logic       ps2_clk_drive_low,
  output logic       ps2_data_drive_low,
  output logic       tx_done,
  output logic       tx_abort
);
  localparam int TICKS_US = CLK_HZ / 1_000_000;
  localparam int HALF_CYC = TICKS_US * HALF_US;
  localparam int LEAD_CYC = TICKS_US * LEAD_US;
  localparam int IDLE_CYC = TICKS_US * IDLE_US;
  localparam int MAX_CYC  = (IDLE_CYC > HALF_CYC) ? IDLE_CYC : HALF_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);
  localparam int GUARD    = SYNC_STAGES + 2;   // settle time after own release
  localparam int BIT_W    = $clog2(FRAME_BITS + 1);

  logic [1:0]       lines_s;
  logic             clk_s, dat_s;
  tx_state_t        st;
  logic [CNT_W-1:0] cnt, lim;
  logic [BIT_W-1:0] bitn;
  logic             phase_end, bus_idle, inhibit, accept, tmr_clr, shift_en, frame_lsb;

  ps2tx_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d_in({ps2_clk_in, ps2_data_in}), .d_out(lines_s)
  );
  assign clk_s = lines_s[1];
  assign dat_s = lines_s[0];

  always_comb begin
    lim       = (st == S_WAIT) ? CNT_W'(IDLE_CYC - 1) : CNT_W'(HALF_CYC - 1);
    phase_end = (cnt == lim);
    bus_idle  = clk_s & dat_s;
    // only meaningful while this block releases the clock
    inhibit   = (st == S_HIGH) && (cnt >= CNT_W'(GUARD)) && !clk_s;
    accept    = (st == S_IDLE) && tx_valid;
    tmr_clr   = (st == S_IDLE) || phase_end || inhibit || ((st == S_WAIT) && !bus_idle);
    shift_en  = (st == S_LOW) && phase_end;
  end

  ps2tx_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst(rst), .clr(tmr_clr), .count(cnt)
  );

  ps2tx_frame frame_i (
    .clk(clk), .rst(rst), .load(accept), .shift(shift_en),
    .byte_in(tx_byte), .bit_out(frame_lsb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st                 <= S_IDLE;
      bitn               <= '0;
      tx_ready           <= 1'b1;
      ps2_clk_drive_low  <= 1'b0;
      ps2_data_drive_low <= 1'b0;
      tx_done            <= 1'b0;
      tx_abort           <= 1'b0;
    end else begin
      tx_done  <= 1'b0;
      tx_abort <= 1'b0;
      case (st)
        S_IDLE: begin
          if (accept) begin
            st       <= S_WAIT;
            tx_ready <= 1'b0;
          end
        end
        S_WAIT: begin
          if (bus_idle && phase_end) begin
            st   <= S_HIGH;
            bitn <= '0;
          end
        end
        S_HIGH: begin
          if (inhibit) begin
            st                 <= S_IDLE;
            ps2_clk_drive_low  <= 1'b0;
            ps2_data_drive_low <= 1'b0;
            tx_abort           <= 1'b1;
            tx_ready           <= 1'b1;
          end else begin
            if (cnt == CNT_W'(HALF_CYC - LEAD_CYC - 1))
              ps2_data_drive_low <= ~frame_lsb;
            if (phase_end) begin
              ps2_clk_drive_low <= 1'b1;
              st                <= S_LOW;
            end
          end
        end
        S_LOW: begin
          if (phase_end) begin
            ps2_clk_drive_low <= 1'b0;
            if (bitn == BIT_W'(FRAME_BITS - 1)) begin
              st                 <= S_IDLE;
              ps2_data_drive_low <= 1'b0;
              tx_done            <= 1'b1;
              tx_ready           <= 1'b1;
            end else begin
              bitn <= bitn + 1'b1;
              st   <= S_HIGH;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ps2_dev_tx_chk.sv
module ps2_dev_tx_chk #(
  parameter int HALF_CYC = 40
) (
  input logic clk,
  input logic rst,
  input logic tx_ready,
  input logic clk_dl,
  input logic dat_dl,
  input logic tx_done,
  input logic tx_abort
);
  logic [31:0] low_len;
  always_ff @(posedge clk) begin
    if (rst) low_len <= '0;
    else     low_len <= clk_dl ? low_len + 1 : 32'd0;
  end

  // R1: lines released right after reset
  p_reset_release_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!clk_dl && !dat_dl && !tx_done && !tx_abort));

  // R3: each low phase lasts a full half period
  p_low_len_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_dl) |-> (low_len == HALF_CYC));

  // R4: data moves only while the clock is released
  p_data_in_high_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(dat_dl) |-> !clk_dl);

  // R6: abort leaves both lines released
  p_abort_release_r6: assert property (@(posedge clk) disable iff (rst)
    tx_abort |-> (!clk_dl && !dat_dl && !tx_done));

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !tx_done);

  // R8: nothing driven while ready
  p_ready_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> (!clk_dl && !dat_dl));
endmodule

bind ps2_dev_tx ps2_dev_tx_chk #(.HALF_CYC(HALF_CYC)) chk_i (
  .clk(clk), .rst(rst), .tx_ready(tx_ready),
  .clk_dl(ps2_clk_drive_low), .dat_dl(ps2_data_drive_low),
  .tx_done(tx_done), .tx_abort(tx_abort)
);

// File: tb/ps2_dev_tx_tb_top.sv
module ps2_dev_tx_tb_top;
  localparam int SYS_HZ = 1_000_000;   // 1 tick per microsecond for short runs
  localparam int HALF   = 40;
  localparam int LEAD   = 20;
  localparam int IDLE   = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [7:0] tx_byte = 8'h00;
  logic tx_valid = 1'b0;
  logic host_clk_low = 1'b0;
  logic tx_ready, clk_dl, dat_dl, tx_done, tx_abort;
  logic clk_line, dat_line;
  assign clk_line = !(clk_dl || host_clk_low);
  assign dat_line = !dat_dl;

  int total = 0;
  int bad   = 0;

  ps2_dev_tx #(.CLK_HZ(SYS_HZ)) dut_i (
    .clk(clk), .rst(rst), .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .ps2_clk_in(clk_line), .ps2_data_in(dat_line),
    .ps2_clk_drive_low(clk_dl), .ps2_data_drive_low(dat_dl),
    .tx_done(tx_done), .tx_abort(tx_abort)
  );

  // {byte, expected odd-parity bit}
  localparam logic [8:0] VEC [0:6] = '{
    {8'h00, 1'b1}, {8'hFF, 1'b1}, {8'hA5, 1'b1}, {8'h01, 1'b0},
    {8'h80, 1'b0}, {8'h7E, 1'b1}, {8'h3B, 1'b0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Offers byte b, acts as the host on the wires and collects sampled bits.
  task automatic run_frame(input logic [7:0] b, input int inh_fall, input bit busy_poke,
                           input int pre_hold, output logic [10:0] bits, output int nfalls,
                           output bit got_done, output bit got_abort);
    int hi_run, lo_run, since, hold;
    bit pcl, pdl, chg, timing, fired, poked, viol, early;
    bits = '1; nfalls = 0; got_done = 0; got_abort = 0;
    hi_run = 0; lo_run = 0; since = 0; hold = 0;
    pcl = 1; pdl = 1; chg = 0; timing = (inh_fall < 0); fired = 0; poked = 0;
    viol = 0; early = 0;
    if (pre_hold > 0) host_clk_low = 1'b1;
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_byte = b; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    for (int cyc = 0; cyc < 4000 && !got_done && !got_abort; cyc++) begin
      @(negedge clk);
      tx_valid = 1'b0;
      if (pre_hold > 0) begin
        if (cyc < pre_hold && (clk_dl || dat_dl)) viol = 1;
        if (cyc == pre_hold) host_clk_low = 1'b0;
        if (cyc > pre_hold && cyc <= pre_hold + IDLE && (clk_dl || dat_dl)) early = 1;
      end
      since++;
      if (dat_line != pdl) begin
        if (!clk_line) check(0, "R4", "data changed while clock low", 0, 1);
        since = 0; chg = 1;
      end
      if (clk_line && !pcl) begin
        if (timing && nfalls > 0) check(lo_run == HALF, "R3", "low phase cycles", lo_run, HALF);
        hi_run = 0; chg = 0;
      end
      if (!clk_line && pcl && !host_clk_low) begin
        nfalls++;
        if (nfalls <= 11) bits[nfalls-1] = dat_line;
        if (timing && nfalls > 1) check(hi_run == HALF, "R3", "high phase cycles", hi_run, HALF);
        if (timing && chg) check(since == LEAD, "R4", "data change to fall", since, LEAD);
        lo_run = 0;
      end
      if (clk_line) hi_run++; else lo_run++;
      if (busy_poke && nfalls == 2 && !poked) begin
        check(!tx_ready, "R8", "ready low mid-frame", int'(tx_ready), 0);
        tx_byte = 8'hC3; tx_valid = 1'b1; poked = 1;
      end
      if (inh_fall >= 0 && !fired && nfalls == inh_fall && clk_line && hi_run == 10) begin
        host_clk_low = 1'b1; hold = 150; fired = 1;
      end else if (host_clk_low && hold > 0) begin
        hold--;
        if (hold == 0) host_clk_low = 1'b0;
      end
      got_done  = tx_done;
      got_abort = tx_abort;
      if (got_done)  check(!clk_dl && !dat_dl, "R7", "lines at done", int'({clk_dl, dat_dl}), 0);
      if (got_abort) check(!clk_dl && !dat_dl, "R6", "lines at abort", int'({clk_dl, dat_dl}), 0);
      pcl = clk_line; pdl = dat_line;
    end
    tx_valid = 1'b0;
    @(negedge clk);
    check(!tx_done && !tx_abort, "R7", "pulse width one cycle", int'({tx_done, tx_abort}), 0);
    if (got_done) check(tx_ready, "R7", "ready after done", int'(tx_ready), 1);
    if (pre_hold > 0) begin
      check(!viol, "R5", "drive while host inhibits", int'(viol), 0);
      check(!early, "R5", "drive before idle window", int'(early), 0);
    end
    while (host_clk_low) begin
      @(negedge clk);
      if (hold > 0) hold--;
      if (hold == 0) host_clk_low = 1'b0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [10:0] bits, exp;
    int nf;
    bit dn, ab, quiet;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(!clk_dl && !dat_dl, "R1", "lines in reset", int'({clk_dl, dat_dl}), 0);
    check(tx_ready && !tx_done && !tx_abort, "R1", "status in reset",
          int'({tx_ready, tx_done, tx_abort}), 4);
    rst = 1'b0;
    @(negedge clk);
    check(!clk_dl && !dat_dl && tx_ready, "R1", "after reset", int'({clk_dl, dat_dl, tx_ready}), 1);

    // R2/R3/R4/R7 across the vector table, R8 poke on one entry
    for (int v = 0; v < 7; v++) begin
      run_frame(VEC[v][8:1], -1, (v == 2), 0, bits, nf, dn, ab);
      exp = {1'b1, VEC[v][0], VEC[v][8:1], 1'b0};
      check(bits == exp, "R2", "frame bits", int'(bits), int'(exp));
      check(nf == 11, "R2", "falling edges", nf, 11);
      check(dn && !ab, "R7", "done reported", int'({dn, ab}), 2);
      if (v == 2) begin
        quiet = 1;
        for (int k = 0; k < 200; k++) begin
          @(negedge clk);
          if (clk_dl || dat_dl || !tx_ready) quiet = 0;
        end
        check(quiet, "R8", "busy offer ignored", int'(quiet), 1);
      end
    end

    // R5: host inhibits before frame
    run_frame(8'h5A, -1, 0, 300, bits, nf, dn, ab);
    exp = {1'b1, 1'b1, 8'h5A, 1'b0};
    check(bits == exp && dn, "R5", "frame after inhibit release", int'(bits), int'(exp));

    // R6: abort after third fall
    run_frame(8'hE7, 3, 0, 0, bits, nf, dn, ab);
    check(ab && !dn, "R6", "abort mid-frame", int'({dn, ab}), 1);
    check(nf == 3, "R6", "falls before abort", nf, 3);

    run_frame(8'h12, -1, 0, 0, bits, nf, dn, ab);
    exp = {1'b1, 1'b1, 8'h12, 1'b0};
    check(bits == exp && dn, "R6", "recovery frame", int'(bits), int'(exp));

    // R9: final check after tenth fall aborts
    run_frame(8'h99, 10, 0, 0, bits, nf, dn, ab);
    check(ab && !dn, "R9", "abort in final high phase", int'({dn, ab}), 1);
    check(nf == 10, "R9", "falls before final abort", nf, 10);

    // R9: hold after completion produces no abort
    run_frame(8'h44, -1, 0, 0, bits, nf, dn, ab);
    check(dn, "R9", "frame done", int'(dn), 1);
    host_clk_low = 1'b1;
    quiet = 1;
    for (int k = 0; k < 150; k++) begin
      @(negedge clk);
      if (tx_abort || clk_dl || dat_dl) quiet = 0;
    end
    host_clk_low = 1'b0;
    check(quiet, "R9", "no abort after done", int'(quiet), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule